// File: doc/BRIEF.md
# Read-Buffer Dependency Tracker

This block counts, for each of a set of read buffers, how many responses still waiting in an in-order response queue will be served from that buffer. Every time the queue takes an entry, the block receives a strobe and a one-hot word naming the buffer that entry refers to. That buffer's count goes up by one. Every time the queue gives up its head entry, the block receives a strobe and the head entry's one-hot buffer word. That buffer's count goes down by one. Replacement logic reads the per-buffer dependency vector so that it never evicts a buffer that a queued response still needs. The front end reads the all-buffers flag and holds off new requests while no buffer is free of dependencies.

Each buffer has its own counter slot, and each slot is a small state machine. SLOT_IDLE means the count is zero. SLOT_BUSY means the count lies between one and the maximum minus one. SLOT_FULL means the count equals the maximum, which is the queue depth. The slot moves between states as follows:
- Increment: SLOT_IDLE to SLOT_BUSY. When the maximum is 1, it goes straight to SLOT_FULL.
- Increment at one below the maximum: SLOT_BUSY to SLOT_FULL.
- Decrement at one: SLOT_BUSY to SLOT_IDLE.
- Decrement: SLOT_FULL to SLOT_BUSY. When the maximum is 1, it goes to SLOT_IDLE.

An increment in SLOT_FULL and a decrement in SLOT_IDLE are illegal. The slot stays where it is and reports a fault. A separate flag stage combines the slot outputs with the enable input and registers the error pulse.

Top module: `bufdep_tracker`

## Requirements
- R1: A push (`push_i`=1) with bit i set in `push_sel_i` raises the count of buffer i by one. `dep_o[i]` is high from the first clock edge after the push.
- R2: A pop (`pop_i`=1) with bit i set in `pop_sel_i` lowers the count of buffer i by one. `dep_o[i]` falls after the edge that brings the count to zero.
- R3: While `enable_i` is high, `dep_o[i]` is 1 exactly when the count of buffer i is non-zero.
- R4: `all_dep_o` is 1 exactly when every bit of `dep_o` is 1.
- R5: While `enable_i` is low, `dep_o` and `all_dep_o` are zero. Pushes and pops are ignored: counts are held, and no error is raised. The earlier dependencies reappear once `enable_i` returns high.
- R6: A push and a pop that select the same buffer in one cycle leave its count unchanged and raise no error. This holds even when the count is zero or at the maximum.
- R7: A push to a buffer whose count equals FIFO_DEPTH, or a pop from a buffer whose count is zero, changes nothing. It sets `err_o` high for exactly the one cycle after that edge.
- R8: A push or pop whose select word is all zero changes no count and raises no error.
- R9: Reset (`rst_n` low, asynchronous) clears all counts to zero and clears `err_o`.
- R10: A push to one buffer and a pop from a different buffer in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Tracker enable; when low, outputs are forced to zero and strobes are ignored |
| push_i | input | 1 | Response-queue write strobe |
| push_sel_i | input | NUM_BUF | One-hot buffer select of the entry being written |
| pop_i | input | 1 | Response-queue read strobe |
| pop_sel_i | input | NUM_BUF | One-hot buffer select of the head entry being read |
| dep_o | output | NUM_BUF | Per-buffer dependency flags |
| all_dep_o | output | 1 | Every buffer has a dependency |
| err_o | output | 1 | One-cycle pulse after an overflowing push or underflowing pop |

## Verification
Two functions can fall in the same cycle: a push and a pop. The interesting cases are when both target the same buffer, and when they target different buffers. Directed steps provoke the same-buffer case with the count at zero, in the middle of its range, and at the maximum. In each case the bench expects the flags to stay unchanged and no error pulse. When the two strobes target different buffers, the bench expects both counts to move. A seeded random phase then draws both strobes independently every cycle, with one-hot or empty selects. A bench reference model judges every cycle's dependency vector, the all-buffers flag and the error pulse.

// File: rtl/bufdep_pkg.sv
package bufdep_pkg;

    typedef enum logic [1:0] {
        SLOT_IDLE = 2'd0,
        SLOT_BUSY = 2'd1,
        SLOT_FULL = 2'd2
    } slot_state_e;

    typedef struct packed {
        logic up;
        logic down;
    } slot_step_t;

endpackage

// File: rtl/bufdep_slot.sv
module bufdep_slot
    import bufdep_pkg::*;
#(
    parameter int MAX_CNT = 4,
    parameter int CNT_W   = $clog2(MAX_CNT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step_en_i,
    input  logic inc_i,
    input  logic dec_i,
    output logic held_o,
    output logic fault_o
);

    localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_BELOW = CNT_W'(MAX_CNT - 1);

    slot_state_e     state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    slot_step_t      req;
    logic            do_up, do_down;

    // Opposing strobes on the same slot cancel before any range check.
    always_comb begin
        req.up   = step_en_i & inc_i & ~dec_i;
        req.down = step_en_i & dec_i & ~inc_i;
    end

    always_comb begin
        do_up   = req.up   & (state_q != SLOT_FULL);
        do_down = req.down & (state_q != SLOT_IDLE);
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (do_up) begin
            cnt_d = cnt_q + CNT_ONE;
        end else if (do_down) begin
            cnt_d = cnt_q - CNT_ONE;
        end
        unique case (state_q)
            SLOT_IDLE: begin
                if (do_up) begin
                    state_d = (MAX_CNT == 1) ? SLOT_FULL : SLOT_BUSY;
                end
            end
            SLOT_BUSY: begin
                if (do_up && (cnt_q == CNT_BELOW)) begin
                    state_d = SLOT_FULL;
                end else if (do_down && (cnt_q == CNT_ONE)) begin
                    state_d = SLOT_IDLE;
                end
            end
            SLOT_FULL: begin
                if (do_down) begin
                    state_d = (MAX_CNT == 1) ? SLOT_IDLE : SLOT_BUSY;
                end
            end
            default: state_d = SLOT_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SLOT_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        held_o  = (state_q != SLOT_IDLE);
        fault_o = (req.up & (state_q == SLOT_FULL)) |
                  (req.down & (state_q == SLOT_IDLE));
    end

endmodule

// File: rtl/bufdep_flags.sv
module bufdep_flags #(
    parameter int NUM_BUF = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable_i,
    input  logic [NUM_BUF-1:0] held_i,
    input  logic [NUM_BUF-1:0] fault_i,
    output logic [NUM_BUF-1:0] dep_o,
    output logic               all_dep_o,
    output logic               err_o
);

    logic err_q;

    always_comb begin
        dep_o     = enable_i ? held_i : '0;
        all_dep_o = enable_i & (&held_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else begin
            err_q <= |fault_i;
        end
    end

    assign err_o = err_q;

endmodule

// File: rtl/bufdep_tracker.sv
module bufdep_tracker #(
    parameter int NUM_BUF    = 4,
    parameter int FIFO_DEPTH = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable_i,
    input  logic               push_i,
    input  logic [NUM_BUF-1:0] push_sel_i,
    input  logic               pop_i,
    input  logic [NUM_BUF-1:0] pop_sel_i,
    output logic [NUM_BUF-1:0] dep_o,
    output logic               all_dep_o,
    output logic               err_o
);

    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

    logic [NUM_BUF-1:0] held;
    logic [NUM_BUF-1:0] fault;

    for (genvar g = 0; g < NUM_BUF; g++) begin : gen_slot
        bufdep_slot #(
            .MAX_CNT(FIFO_DEPTH),
            .CNT_W  (CNT_W)
        ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .step_en_i(enable_i),
            .inc_i    (push_i & push_sel_i[g]),
            .dec_i    (pop_i & pop_sel_i[g]),
            .held_o   (held[g]),
            .fault_o  (fault[g])
        );
    end

    bufdep_flags #(
        .NUM_BUF(NUM_BUF)
    ) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable_i (enable_i),
        .held_i   (held),
        .fault_i  (fault),
        .dep_o    (dep_o),
        .all_dep_o(all_dep_o),
        .err_o    (err_o)
    );

endmodule

// File: rtl/bufdep_tracker_checker.sv
module bufdep_tracker_checker #(
    parameter int NUM_BUF = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               enable_i,
    input logic               push_i,
    input logic [NUM_BUF-1:0] push_sel_i,
    input logic               pop_i,
    input logic [NUM_BUF-1:0] pop_sel_i,
    input logic [NUM_BUF-1:0] dep_o,
    input logic               all_dep_o,
    input logic               err_o
);

    AST_PUSH_SETS_DEP: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && push_i && !pop_i && $onehot(push_sel_i)) |=>
        (!enable_i || ((dep_o & $past(push_sel_i)) != '0))); // R1

    AST_ALL_MATCHES_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        all_dep_o == (&dep_o)); // R4

    AST_OFF_IS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |-> (dep_o == '0 && !all_dep_o)); // R5

    AST_OFF_NO_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> !err_o); // R5

    AST_SAME_SLOT_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && push_i && pop_i && $onehot(push_sel_i) && push_sel_i == pop_sel_i) |=>
        !err_o); // R6

    AST_UNDERFLOW_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && pop_i && !push_i && $onehot(pop_sel_i) && ((dep_o & pop_sel_i) == '0)) |=>
        err_o); // R7

    AST_ERR_SINGLE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(enable_i && (push_i || pop_i))); // R7

    AST_ZERO_SEL_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && (!push_i || push_sel_i == '0) && (!pop_i || pop_sel_i == '0)) |=>
        (!err_o && (!enable_i || dep_o == $past(dep_o)))); // R8

endmodule

bind bufdep_tracker bufdep_tracker_checker #(
    .NUM_BUF(NUM_BUF)
) u_bufdep_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable_i  (enable_i),
    .push_i    (push_i),
    .push_sel_i(push_sel_i),
    .pop_i     (pop_i),
    .pop_sel_i (pop_sel_i),
    .dep_o     (dep_o),
    .all_dep_o (all_dep_o),
    .err_o     (err_o)
);

// File: tb/bufdep_tracker_bench.sv
module bufdep_tracker_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NB         = 4;
    localparam int DEPTH      = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable_i = 1'b0;
    logic          push_i = 1'b0;
    logic [NB-1:0] push_sel_i = '0;
    logic          pop_i = 1'b0;
    logic [NB-1:0] pop_sel_i = '0;
    logic [NB-1:0] dep_o;
    logic          all_dep_o;
    logic          err_o;

    int n_checks = 0;
    int n_fails  = 0;
    int model_cnt [NB];
    logic model_err = 1'b0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bufdep_tracker #(
        .NUM_BUF   (NB),
        .FIFO_DEPTH(DEPTH)
    ) u_bufdep_tracker (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable_i  (enable_i),
        .push_i    (push_i),
        .push_sel_i(push_sel_i),
        .pop_i     (pop_i),
        .pop_sel_i (pop_sel_i),
        .dep_o     (dep_o),
        .all_dep_o (all_dep_o),
        .err_o     (err_o)
    );

    function automatic logic [NB-1:0] exp_dep(input logic en);
        logic [NB-1:0] v = '0;
        for (int i = 0; i < NB; i++) v[i] = en && (model_cnt[i] != 0);
        return v;
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Apply one cycle of stimulus, advance the model, check after the edge.
    task automatic step(input string tag, input logic en,
                        input logic pu, input logic [NB-1:0] ps,
                        input logic po, input logic [NB-1:0] qs);
        logic [NB-1:0] d;
        @(negedge clk);
        enable_i = en; push_i = pu; push_sel_i = ps; pop_i = po; pop_sel_i = qs;
        model_err = 1'b0;
        if (en) begin
            for (int i = 0; i < NB; i++) begin
                logic u, w;
                u = pu && ps[i];
                w = po && qs[i];
                if (u && !w) begin
                    if (model_cnt[i] == DEPTH) model_err = 1'b1;
                    else model_cnt[i]++;
                end else if (w && !u) begin
                    if (model_cnt[i] == 0) model_err = 1'b1;
                    else model_cnt[i]--;
                end
            end
        end
        @(posedge clk);
        #1;
        d = exp_dep(en);
        check(tag, "dep_o", 32'(dep_o), 32'(d));
        check(tag, "all_dep_o", 32'(all_dep_o), 32'(&d));
        check(tag, "err_o", 32'(err_o), 32'(model_err));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < NB; i++) model_cnt[i] = 0;
        repeat (3) @(posedge clk);
        #1;
        // R9: reset state
        check("R9", "dep_o in reset", 32'(dep_o), 32'h0);
        check("R9", "err_o in reset", 32'(err_o), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        step("R9", 1'b1, 1'b0, '0, 1'b0, '0);

        step("R1", 1'b1, 1'b1, 4'b0001, 1'b0, '0);
        step("R10", 1'b1, 1'b1, 4'b0100, 1'b1, 4'b0001);
        for (int k = 0; k < DEPTH; k++) step("R1", 1'b1, 1'b1, 4'b0010, 1'b0, '0);
        step("R7", 1'b1, 1'b1, 4'b0010, 1'b0, '0);      // overflow push
        step("R6", 1'b1, 1'b1, 4'b0010, 1'b1, 4'b0010); // same slot at max
        step("R7", 1'b1, 1'b0, '0, 1'b1, 4'b1000);      // underflow pop
        step("R6", 1'b1, 1'b1, 4'b1000, 1'b1, 4'b1000); // same slot at zero
        step("R6", 1'b1, 1'b1, 4'b0100, 1'b1, 4'b0100); // same slot mid-range
        for (int k = 0; k < DEPTH; k++) step("R2", 1'b1, 1'b0, '0, 1'b1, 4'b0010);
        step("R7", 1'b1, 1'b0, '0, 1'b1, 4'b0010);      // max was held at DEPTH
        step("R8", 1'b1, 1'b1, 4'b0000, 1'b1, 4'b0000);
        step("R4", 1'b1, 1'b1, 4'b0001, 1'b0, '0);
        step("R4", 1'b1, 1'b1, 4'b0010, 1'b0, '0);
        step("R4", 1'b1, 1'b1, 4'b1000, 1'b0, '0);
        step("R5", 1'b0, 1'b0, '0, 1'b0, '0);
        step("R5", 1'b0, 1'b0, '0, 1'b1, 4'b0001);
        step("R5", 1'b0, 1'b1, 4'b0010, 1'b0, '0);
        step("R5", 1'b1, 1'b0, '0, 1'b0, '0);
        for (int i = 0; i < NB; i++) begin
            step("R2", 1'b1, 1'b0, '0, 1'b1, 4'(1 << i));
        end
        for (int i = 0; i < NB; i++) begin
            step("R2", 1'b1, 1'b0, '0, 1'b1, 4'(1 << i));
        end

        // R3: seeded random traffic against the reference model
        for (int c = 0; c < 3000; c++) begin
            logic en, pu, po;
            logic [NB-1:0] ps, qs;
            en = ($urandom % 10) != 0;
            pu = ($urandom % 2) == 1;
            po = ($urandom % 2) == 1;
            ps = (($urandom % 8) == 0) ? '0 : 4'(1 << ($urandom % NB));
            qs = (($urandom % 8) == 0) ? '0 : 4'(1 << ($urandom % NB));
            if (($urandom % 6) == 0) qs = ps;
            step("R3", en, pu, ps, po, qs);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule